// File: doc/BRIEF.md
# PCI Posted Write Combiner

This block sits between a host that issues single-word posted write requests and the master side of a 32-bit PCI bus. It keeps one burst open and, for each arriving request, either appends it to that burst or closes the burst and hands it to the PCI side as one descriptor. The descriptor carries a start address, a command code, a beat count and all the data beats with their byte enables in parallel.

A write joins the open burst only if it is a memory write of the same kind as the burst and its word address is the one directly after the last beat held. Any other request, including a write that comes after an ordering barrier, ends the burst first. A burst also ends when it is full or when no request has arrived for a fixed number of cycles. While a closed burst waits for the PCI side, the host side is stalled through its ready signal.

Top module: `pci_wr_merger`

## Requirements
- R1: Only command codes 4'b0111 (memory write) and 4'b1111 (memory write and invalidate) can be merged; any other code closes an open burst and is then sent alone as a descriptor of length 1 carrying that code.
- R2: A mergeable write is appended only if its word address (req_addr[31:2]) equals the burst start word plus the current beat count; req_addr[1:0] are ignored and burst_addr[1:0] read 0.
- R3: A write to a word address below the next expected word closes the open burst, and that write becomes beat 0 of a new burst.
- R4: A write to a word already held in the open burst closes it before the write is taken.
- R5: A request with req_barrier=1 is never merged into the burst open before it; with no burst open the marker changes nothing.
- R6: Beat i of a descriptor sits in burst_data[32*i+:32] with its byte enables in burst_be[4*i+:4]; beat 0 belongs to burst_addr.
- R7: A burst holds at most 16 beats; the edge that accepts the 16th beat also raises burst_valid.
- R8: An open burst that sees no request for 8 consecutive cycles is offered: burst_valid rises after the 8th idle edge following the last acceptance, not earlier.
- R9: A mergeable write whose code differs from the open burst's code closes that burst.
- R10: While burst_valid is high req_ready is low, and the descriptor holds steady until burst_ready is high at a clock edge.
- R11: After reset burst_valid is 0 and req_ready is 1.
- R12: A request that caused a flush is accepted after the descriptor handshake and opens a new burst with itself as beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Host request taken at this edge |
| req_addr | input | 32 | Byte address of the word written |
| req_data | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| req_cmd | input | 4 | PCI command code |
| req_barrier | input | 1 | Ordering barrier precedes this request |
| burst_valid | output | 1 | Descriptor offered to the PCI side |
| burst_ready | input | 1 | PCI side takes the descriptor |
| burst_addr | output | 32 | Start byte address of the burst |
| burst_cmd | output | 4 | Command code of the burst |
| burst_len | output | 5 | Number of beats, 1 to 16 |
| burst_data | output | 512 | Data beats, beat 0 in the low word |
| burst_be | output | 64 | Byte enables per beat, beat 0 in the low nibble |

## Verification
A flush caused by a request is visible right after the edge at which that request was refused, a full burst is visible right after the edge that took its 16th beat, and an idle flush appears after the 8th idle edge; the bench samples each of these at the falling edge that follows the relevant rising edge. Descriptors in the table run are compared at the falling edge before the handshake edge, when the offered values are settled. The refused request is checked to enter one edge after the handshake, and the idle test looks both one edge early and exactly on time so a shifted timeout is caught.

// File: rtl/wrm_pkg.sv
// Package: shared command codes and a helper for the write combiner.
// Assumes PCI command encoding on a 4-bit field.
package wrm_pkg;
    localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

    // True for the two command codes that may be merged.
    function automatic logic cmd_mergeable(input logic [3:0] cmd);
        return (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WRI);
    endfunction
endpackage

// File: rtl/wrm_merge_check.sv
// Decides whether an incoming request may join the open burst.
// Assumes word addressing (byte address bits [1:0] ignored) and that
// next_word already points one word past the last held beat.
module wrm_merge_check #(
    parameter int WORD_W = 30
) (
    input  logic              burst_open,
    input  logic [3:0]        open_cmd,
    input  logic [WORD_W-1:0] next_word,
    input  logic [WORD_W-1:0] in_word,
    input  logic [3:0]        in_cmd,
    input  logic              in_barrier,
    output logic              in_mergeable,
    output logic              can_append
);
    import wrm_pkg::*;

    // Combine command, ordering and address conditions.
    always_comb begin
        in_mergeable = cmd_mergeable(in_cmd);
        can_append   = burst_open && in_mergeable && (in_cmd == open_cmd)
                       && !in_barrier && (in_word == next_word);
    end
endmodule

// File: rtl/wrm_beat_store.sv
// Register file holding the data and byte enables of the open burst.
// One slot per beat; slot wr_idx is written when wr_en is high.
module wrm_beat_store #(
    parameter int MAX_BEATS = 16,
    parameter int DATA_W    = 32,
    localparam int BE_W     = DATA_W / 8,
    localparam int IDX_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [BE_W-1:0]             wr_be,
    output logic [MAX_BEATS*DATA_W-1:0] all_data,
    output logic [MAX_BEATS*BE_W-1:0]   all_be
);
    for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
        logic [DATA_W-1:0] slot_d;
        logic [BE_W-1:0]   slot_b;

        // Capture one beat into its own slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_d <= '0;
                slot_b <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_d <= wr_data;
                slot_b <= wr_be;
            end
        end

        assign all_data[g*DATA_W +: DATA_W] = slot_d;
        assign all_be[g*BE_W +: BE_W]       = slot_b;
    end
endmodule

// File: rtl/wrm_idle_timer.sv
// Counts consecutive idle cycles of an open burst and pulses expire on
// the cycle that completes IDLE_CYCLES of them. Any non-idle cycle clears it.
module wrm_idle_timer #(
    parameter int IDLE_CYCLES = 8,
    localparam int CNT_W      = $clog2(IDLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_tick,
    output logic expire
);
    logic [CNT_W-1:0] idle_cnt;

    // Expire when the last idle cycle of the window is reached.
    assign expire = idle_tick && (idle_cnt == CNT_W'(IDLE_CYCLES - 1));

    // Advance on idle cycles, restart on anything else or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idle_cnt <= '0;
        else if (!idle_tick || expire) idle_cnt <= '0;
        else                        idle_cnt <= idle_cnt + 1'b1;
    end

    assert_idle_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt < CNT_W'(IDLE_CYCLES));
endmodule

// File: rtl/pci_wr_merger.sv
// Top of the posted write combiner. Holds one open burst, appends
// eligible contiguous writes and offers the burst to the PCI side on
// a barrier, mismatch, full buffer or idle timeout. The host is stalled
// while a descriptor waits. Assumes word-aligned single-beat requests.
module pci_wr_merger #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int MAX_BEATS   = 16,
    parameter int IDLE_CYCLES = 8,
    localparam int BE_W       = DATA_W / 8,
    localparam int WORD_W     = ADDR_W - 2,
    localparam int LEN_W      = $clog2(MAX_BEATS + 1),
    localparam int IDX_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_data,
    input  logic [BE_W-1:0]             req_be,
    input  logic [3:0]                  req_cmd,
    input  logic                        req_barrier,
    output logic                        burst_valid,
    input  logic                        burst_ready,
    output logic [ADDR_W-1:0]           burst_addr,
    output logic [3:0]                  burst_cmd,
    output logic [LEN_W-1:0]            burst_len,
    output logic [MAX_BEATS*DATA_W-1:0] burst_data,
    output logic [MAX_BEATS*BE_W-1:0]   burst_be
);
    import wrm_pkg::*;

    logic              pend;
    logic [LEN_W-1:0]  cnt;
    logic [WORD_W-1:0] start_word;
    logic [WORD_W-1:0] next_word;
    logic [3:0]        open_cmd;
    logic              empty;
    logic              in_mergeable;
    logic              can_append;
    logic              accept;
    logic              idle_tick;
    logic              idle_expire;
    logic              close_now;
    logic [WORD_W-1:0] in_word;

    assign in_word = req_addr[ADDR_W-1:2];
    assign empty   = (cnt == '0);

    wrm_merge_check #(.WORD_W(WORD_W)) u_check (
        .burst_open  (!empty && !pend),
        .open_cmd    (open_cmd),
        .next_word   (next_word),
        .in_word     (in_word),
        .in_cmd      (req_cmd),
        .in_barrier  (req_barrier),
        .in_mergeable(in_mergeable),
        .can_append  (can_append)
    );

    // Host handshake and flush decision for this cycle.
    always_comb begin
        req_ready = !pend && (empty || can_append);
        accept    = req_valid && req_ready;
        idle_tick = !empty && !pend && !req_valid;
        close_now = !empty && !pend && ((req_valid && !can_append) || idle_expire);
    end

    wrm_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_tick(idle_tick),
        .expire   (idle_expire)
    );

    wrm_beat_store #(.MAX_BEATS(MAX_BEATS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_idx  (cnt[IDX_W-1:0]),
        .wr_data (req_data),
        .wr_be   (req_be),
        .all_data(burst_data),
        .all_be  (burst_be)
    );

    // Burst bookkeeping: open, extend, close and release the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            cnt        <= '0;
            start_word <= '0;
            next_word  <= '0;
            open_cmd   <= '0;
        end else if (pend) begin
            if (burst_ready) begin
                pend <= 1'b0;
                cnt  <= '0;
            end
        end else if (accept) begin
            next_word <= in_word + 1'b1;
            cnt       <= cnt + 1'b1;
            if (empty) begin
                start_word <= in_word;
                open_cmd   <= req_cmd;
                pend       <= !in_mergeable || (MAX_BEATS == 1);
            end else begin
                pend <= (cnt == LEN_W'(MAX_BEATS - 1));
            end
        end else if (close_now) begin
            pend <= 1'b1;
        end
    end

    assign burst_valid = pend;
    assign burst_addr  = {start_word, 2'b00};
    assign burst_cmd   = open_cmd;
    assign burst_len   = cnt;

    assert_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (burst_len != '0) && (burst_len <= LEN_W'(MAX_BEATS)));

    assert_full_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (cnt == LEN_W'(MAX_BEATS - 1))) |=> burst_valid);

    assert_stall_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> !req_ready);

    assert_hold_offer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !burst_ready) |=>
            (burst_valid && $stable(burst_addr) && $stable(burst_len) && $stable(burst_cmd)));

    assert_single_other_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !cmd_mergeable(burst_cmd)) |-> (burst_len == LEN_W'(1)));
endmodule

// File: tb/pci_wr_merger_bench.sv
module pci_wr_merger_bench;
    localparam int NB = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_data = '0;
    logic [3:0]   req_be = '0;
    logic [3:0]   req_cmd = '0;
    logic         req_barrier = 1'b0;
    logic         burst_valid;
    logic         burst_ready = 1'b0;
    logic [31:0]  burst_addr;
    logic [3:0]   burst_cmd;
    logic [4:0]   burst_len;
    logic [NB*32-1:0] burst_data;
    logic [NB*4-1:0]  burst_be;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    int exp_idx = 0;

    always #10 clk = ~clk;

    pci_wr_merger u_pci_wr_merger (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .req_cmd(req_cmd), .req_barrier(req_barrier),
        .burst_valid(burst_valid), .burst_ready(burst_ready),
        .burst_addr(burst_addr), .burst_cmd(burst_cmd), .burst_len(burst_len),
        .burst_data(burst_data), .burst_be(burst_be)
    );

    // request table: {addr, cmd, barrier}
    localparam logic [36:0] REQ_TAB [11] = '{
        {32'h0000_0100, 4'b0111, 1'b0},
        {32'h0000_0104, 4'b0111, 1'b0},
        {32'h0000_0108, 4'b0111, 1'b0},
        {32'h0000_010C, 4'b0111, 1'b1},
        {32'h0000_0110, 4'b1111, 1'b0},
        {32'h0000_0114, 4'b1111, 1'b0},
        {32'h0000_0114, 4'b1111, 1'b0},
        {32'h0000_00F0, 4'b1111, 1'b0},
        {32'h0000_0200, 4'b1111, 1'b0},
        {32'h0000_0300, 4'b0011, 1'b0},
        {32'h0000_0400, 4'b0111, 1'b0}
    };
    // expected descriptors: {addr, cmd, len}
    localparam logic [40:0] EXP_TAB [8] = '{
        {32'h0000_0100, 4'b0111, 5'd3},   // R5 barrier
        {32'h0000_010C, 4'b0111, 5'd1},   // R9 cmd change
        {32'h0000_0110, 4'b1111, 5'd2},   // R4 overlap
        {32'h0000_0114, 4'b1111, 5'd1},   // R3 lower address
        {32'h0000_00F0, 4'b1111, 5'd1},   // R2 gap
        {32'h0000_0200, 4'b1111, 5'd1},   // R1 other command
        {32'h0000_0300, 4'b0011, 5'd1},   // R1 sent alone
        {32'h0000_0400, 4'b0111, 5'd1}    // R8 idle
    };

    function automatic logic [31:0] dat_of(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction
    function automatic logic [3:0] be_of(input logic [31:0] a);
        return a[5:2] | 4'b0001;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_beats(input logic [31:0] a0, input int len, input string tag);
        for (int i = 0; i < len; i++) begin
            logic [31:0] a;
            a = a0 + 32'(4 * i);
            check(burst_data[32*i +: 32] == dat_of(a), tag, 64'(burst_data[32*i +: 32]), 64'(dat_of(a)));
            check(burst_be[4*i +: 4] == be_of(a), tag, 64'(burst_be[4*i +: 4]), 64'(be_of(a)));
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [3:0] c, input logic b);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_barrier = b;
        req_data = dat_of(a); req_be = be_of(a);
    endtask

    task automatic send(input logic [31:0] a, input logic [3:0] c, input logic b);
        @(negedge clk);
        drive(a, c, b);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    // descriptor monitor for the table run, sampled before the handshake edge
    always @(negedge clk) begin
        if (mon_on && burst_valid && burst_ready) begin
            if (exp_idx < 8) begin
                check(burst_addr == EXP_TAB[exp_idx][40:9], "R2/R3 addr",
                      64'(burst_addr), 64'(EXP_TAB[exp_idx][40:9]));
                check(burst_cmd == EXP_TAB[exp_idx][8:5], "R1/R9 cmd",
                      64'(burst_cmd), 64'(EXP_TAB[exp_idx][8:5]));
                check(burst_len == EXP_TAB[exp_idx][4:0], "R4/R5 len",
                      64'(burst_len), 64'(EXP_TAB[exp_idx][4:0]));
                check_beats(EXP_TAB[exp_idx][40:9], int'(EXP_TAB[exp_idx][4:0]), "R6 beat");
            end else begin
                check(1'b0, "R2 extra descriptor", 64'(burst_addr), 64'h0);
            end
            exp_idx++;
        end
    end

    initial begin
        #4_000_000;
        check(1'b0, "watchdog", 64'h0, 64'h1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(burst_valid == 1'b0, "R11 valid", 64'(burst_valid), 64'h0);
        check(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'h1);

        // table run with the PCI side always ready
        burst_ready = 1'b1;
        mon_on = 1'b1;
        for (int k = 0; k < 11; k++)
            send(REQ_TAB[k][36:5], REQ_TAB[k][4:1], REQ_TAB[k][0]);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (15) @(negedge clk);
        check(exp_idx == 8, "R8 descriptor count", 64'(exp_idx), 64'd8);
        mon_on = 1'b0;

        // full burst with the PCI side stalled (R7, R10, R12)
        burst_ready = 1'b0;
        for (int k = 0; k < NB; k++)
            send(32'h0000_1000 + 32'(4 * k), 4'b0111, 1'b0);
        @(negedge clk);
        drive(32'h0000_1040, 4'b0111, 1'b0);
        #1;
        check(burst_valid == 1'b1, "R7 full offer", 64'(burst_valid), 64'h1);
        check(burst_len == 5'd16, "R7 full len", 64'(burst_len), 64'd16);
        check(burst_addr == 32'h0000_1000, "R7 full addr", 64'(burst_addr), 64'h1000);
        check(req_ready == 1'b0, "R10 stall", 64'(req_ready), 64'h0);
        check_beats(32'h0000_1000, NB, "R6 full beat");
        repeat (3) @(negedge clk);
        #1;
        check(burst_valid && burst_len == 5'd16 && burst_addr == 32'h0000_1000,
              "R10 hold", 64'(burst_len), 64'd16);
        check(req_ready == 1'b0, "R10 still stalled", 64'(req_ready), 64'h0);
        burst_ready = 1'b1;
        @(negedge clk);   // handshake edge passed
        #1;
        check(burst_valid == 1'b0, "R10 release", 64'(burst_valid), 64'h0);
        check(req_ready == 1'b1, "R12 ready after release", 64'(req_ready), 64'h1);
        @(negedge clk);   // request taken
        req_valid = 1'b0;
        burst_ready = 1'b0;

        // idle timeout of the burst just opened by the held request (R8, R12)
        repeat (7) @(negedge clk);
        check(burst_valid == 1'b0, "R8 not early", 64'(burst_valid), 64'h0);
        @(negedge clk);
        check(burst_valid == 1'b1, "R8 on time", 64'(burst_valid), 64'h1);
        check(burst_addr == 32'h0000_1040 && burst_len == 5'd1, "R12 new burst",
              64'(burst_addr), 64'h1040);
        burst_ready = 1'b1;
        @(negedge clk);
        check(burst_valid == 1'b0, "R10 taken", 64'(burst_valid), 64'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule